// File: doc/BRIEF.md
# Reset Source Sequencer with Watchdog

This block produces the internal system reset of a chip from four sources: power-up, an active-low external reset pin, a watchdog that software must keep servicing, and a monitor that watches for a stopped system clock. It reports which source caused the most recent reset on a 2-bit cause output. When reset ends, it sends a one-cycle pulse that tells the processor core to set its stop-disable, non-maskable-mask and interrupt-mask flags.

A small controller drives the sequence. It has three states: POWERUP, HOLD and RUN. POWERUP is entered asynchronously while `por_n` is low. Once `por_n` rises, POWERUP counts 4064 system clocks, which lets the clock settle, and the transition POR_DONE then moves it to RUN. In RUN, three transitions lead to HOLD, checked in this priority order: CLK_LOSS, EXT_PIN, then WDOG_TIMEOUT. HOLD keeps reset asserted while the pin is still low or a clock fault is still flagged. It then counts a fixed hold interval, and the transition HOLD_DONE returns it to RUN. The clock monitor runs from a separate reference clock and asserts reset directly, so reset appears even while the system clock is stopped.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `por_n` rises, `sys_rst` stays high for exactly POR_CYCLES (default 4064) rising clock edges and then falls, with `rst_cause` = 2'b00 (power-up).
- R2: An `ext_rst_n` low level sampled on EXT_MIN_LOW (default 6) consecutive rising edges asserts `sys_rst` after the last of those edges and sets `rst_cause` = 2'b01. A low run one edge shorter causes no reset.
- R3: In HOLD, `sys_rst` stays high while `ext_rst_n` is low. After the pin returns high, `sys_rst` falls on the HOLD_CYCLES-th (default 16) rising edge.
- R4: With `wd_en` high during RUN, the watchdog fires after 2^WD_DIV_BITS × k rising edges and sets `rst_cause` = 2'b10. The factor k is 1 for `wd_scale` = 0, 2 for `wd_scale` = 1, and 4 for `wd_scale` = 2 or 3.
- R5: A service write of 8'h55 immediately followed by a write of 8'hAA restarts the watchdog count from zero. A write of 8'hAA that does not directly follow 8'h55 has no effect on the timeout, and any other value written between the two cancels the sequence.
- R6: While `wd_en` is low, the watchdog never causes a reset.
- R7: With `cm_en` high, if the system clock shows no edges for CM_LIMIT (default 8) reference-clock cycles, `sys_rst` is asserted with no system clock running. When the clock returns, `rst_cause` = 2'b11. With `cm_en` low, a stopped clock causes no reset.
- R8: `ccr_set` is high for exactly one clock cycle, namely the first cycle in which `sys_rst` is low after any reset.
- R9: When several sources trigger in the same cycle, the recorded cause follows the priority clock loss, then external pin, then watchdog.
- R10: `rst_cause` keeps its value throughout RUN until the next reset, whichever source causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ref_clk | input | 1 | Independent reference clock for the clock monitor |
| por_n | input | 1 | Power-good input, low while the oscillator is not yet running (asynchronous) |
| ext_rst_n | input | 1 | External reset pin, active low, sampled on `clk` |
| wd_en | input | 1 | Watchdog enable |
| wd_scale | input | 2 | Watchdog scale select (0: ×1, 1: ×2, 2/3: ×4) |
| svc_we | input | 1 | Write strobe for the watchdog service register |
| svc_data | input | 8 | Service register write data |
| cm_en | input | 1 | Clock monitor enable |
| sys_rst | output | 1 | System reset, active high |
| rst_cause | output | 2 | Cause of the last reset: 00 power-up, 01 pin, 10 watchdog, 11 clock loss |
| ccr_set | output | 1 | One-cycle pulse on release that sets the core's mask flags |

## Verification
The external pin filter and the watchdog terminal count can finish in the same clock edge. To provoke this, the bench enables the watchdog at scale ×1 and starts a low pulse on the pin exactly six edges before the watchdog would expire. The only correct outcome is a single reset recorded with the pin code 01: a watchdog code, or a second reset entry in the scoreboard, is a failure. A stopped clock is also combined with the clock-loss priority, since the flag latched while the clock was absent must win on the first edge after the clock returns.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
    typedef enum logic [1:0] {
        CAUSE_POR  = 2'b00,
        CAUSE_EXT  = 2'b01,
        CAUSE_WDOG = 2'b10,
        CAUSE_CLK  = 2'b11
    } cause_t;

    typedef enum logic [1:0] {
        ST_POWERUP = 2'b00,
        ST_HOLD    = 2'b01,
        ST_RUN     = 2'b10
    } seq_state_t;
endpackage

// File: rtl/rsq_pin_filter.sv
`timescale 1ns/1ps
// Counts consecutive low samples of the reset pin; fires once on the last required one.
module rsq_pin_filter #(
    parameter int MIN_LOW = 6
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic trig,
    output logic pin_low
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            low_cnt <= '0;
        else if (pin_n)
            low_cnt <= '0;
        else if (low_cnt != CW'(MIN_LOW))
            low_cnt <= low_cnt + 1'b1;
    end

    assign pin_low = !pin_n;
    assign trig    = !pin_n && (low_cnt == CW'(MIN_LOW - 1));
endmodule

// File: rtl/rsq_wdog.sv
`timescale 1ns/1ps
// Watchdog: fixed power-of-two divider times a 1/2/4 scale, restarted by a two-write key.
module rsq_wdog #(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       active,
    input  logic       enable,
    input  logic [1:0] scale,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       expire
);
    localparam int CW = DIV_BITS + 2;
    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_KICK = 8'hAA;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          armed;
    logic          kick;

    always_comb begin
        unique case (scale)
            2'd0:    last = {2'b00, {DIV_BITS{1'b1}}};
            2'd1:    last = {2'b01, {DIV_BITS{1'b1}}};
            default: last = {2'b11, {DIV_BITS{1'b1}}};
        endcase
    end

    assign kick   = svc_we && (svc_data == KEY_KICK) && armed;
    assign expire = active && enable && (cnt == last);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (!active || !enable || kick)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;

            if (!active)
                armed <= 1'b0;
            else if (svc_we)
                armed <= (svc_data == KEY_ARM);
        end
    end
endmodule

// File: rtl/rsq_clk_mon.sv
`timescale 1ns/1ps
// Watches a toggle flop of the system clock from the reference domain.
module rsq_clk_mon #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic ref_clk,
    input  logic por_n,
    input  logic enable,
    output logic fault
);
    localparam int CW = $clog2(LIMIT + 1);

    logic          tgl;
    logic [2:0]    tg_s;
    logic [1:0]    en_s;
    logic [CW-1:0] idle_cnt;
    logic          edge_seen;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) tgl <= 1'b0;
        else        tgl <= !tgl;
    end

    assign edge_seen = tg_s[2] ^ tg_s[1];

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            tg_s     <= '0;
            en_s     <= '0;
            idle_cnt <= '0;
            fault    <= 1'b0;
        end else begin
            tg_s <= {tg_s[1:0], tgl};
            en_s <= {en_s[0], enable};
            if (edge_seen || !en_s[1])
                idle_cnt <= '0;
            else if (idle_cnt != CW'(LIMIT))
                idle_cnt <= idle_cnt + 1'b1;
            fault <= en_s[1] && !edge_seen && (idle_cnt == CW'(LIMIT));
        end
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
    import rsq_pkg::*;
#(
    parameter int POR_CYCLES  = 4064,
    parameter int EXT_MIN_LOW = 6,
    parameter int WD_DIV_BITS = 15,
    parameter int CM_LIMIT    = 8,
    parameter int HOLD_CYCLES = 16
) (
    input  logic       clk,
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       wd_en,
    input  logic [1:0] wd_scale,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    input  logic       cm_en,
    output logic       sys_rst,
    output logic [1:0] rst_cause,
    output logic       ccr_set
);
    localparam int SEQ_MAX = (POR_CYCLES > HOLD_CYCLES) ? POR_CYCLES : HOLD_CYCLES;
    localparam int CNT_W   = $clog2(SEQ_MAX + 1);

    seq_state_t     state, nxt;
    cause_t         cause, cause_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic           ccr_q;
    logic           ext_trig, pin_low, wd_expire, cm_fault, cm_flag, hold_req;

    rsq_pin_filter #(.MIN_LOW(EXT_MIN_LOW)) u_pin (
        .clk(clk), .por_n(por_n), .pin_n(ext_rst_n), .trig(ext_trig), .pin_low(pin_low)
    );

    rsq_wdog #(.DIV_BITS(WD_DIV_BITS)) u_wdog (
        .clk(clk), .por_n(por_n), .active(state == ST_RUN), .enable(wd_en),
        .scale(wd_scale), .svc_we(svc_we), .svc_data(svc_data), .expire(wd_expire)
    );

    rsq_clk_mon #(.LIMIT(CM_LIMIT)) u_cmon (
        .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .enable(cm_en), .fault(cm_fault)
    );

    // Clock-loss flag: set at once by the reference-domain fault, consumed once RUN is left.
    always_ff @(posedge clk or negedge por_n or posedge cm_fault) begin
        if (!por_n)
            cm_flag <= 1'b0;
        else if (cm_fault)
            cm_flag <= 1'b1;
        else if (state != ST_RUN)
            cm_flag <= 1'b0;
    end

    assign hold_req = pin_low || cm_flag;

    always_comb begin
        nxt       = state;
        cause_nxt = cause;
        cnt_nxt   = cnt;
        unique case (state)
            ST_POWERUP: begin
                if (cnt == CNT_W'(POR_CYCLES - 1)) begin      // POR_DONE
                    nxt     = ST_RUN;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_req) begin
                    cnt_nxt = '0;
                end else if (cnt == CNT_W'(HOLD_CYCLES - 1)) begin  // HOLD_DONE
                    nxt     = ST_RUN;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_RUN: begin
                cnt_nxt = '0;
                if (cm_flag) begin                            // CLK_LOSS
                    nxt       = ST_HOLD;
                    cause_nxt = CAUSE_CLK;
                end else if (ext_trig) begin                  // EXT_PIN
                    nxt       = ST_HOLD;
                    cause_nxt = CAUSE_EXT;
                end else if (wd_expire) begin                 // WDOG_TIMEOUT
                    nxt       = ST_HOLD;
                    cause_nxt = CAUSE_WDOG;
                end
            end
            default: begin
                nxt     = ST_POWERUP;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_POWERUP;
            cause <= CAUSE_POR;
            cnt   <= '0;
            ccr_q <= 1'b0;
        end else begin
            state <= nxt;
            cause <= cause_nxt;
            cnt   <= cnt_nxt;
            ccr_q <= (nxt == ST_RUN) && (state != ST_RUN);
        end
    end

    always_comb begin
        sys_rst   = (state != ST_RUN) || cm_fault;
        rst_cause = cause;
        ccr_set   = ccr_q;
    end
endmodule

// File: rtl/rsq_checker.sv
`timescale 1ns/1ps
module rsq_checker (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       wd_en,
    input logic       sys_rst,
    input logic [1:0] rst_cause,
    input logic       ccr_set
);
    // R8
    ccr_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        ccr_set |=> !ccr_set);

    // R8
    ccr_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        ccr_set |-> (!sys_rst && $past(sys_rst)));

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && $past(!sys_rst)) |-> $stable(rst_cause));

    // R6
    wd_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(sys_rst) && !$past(wd_en)) |-> (rst_cause != 2'b10));

    // R3
    pin_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && !ext_rst_n && rst_cause != 2'b00) |=> sys_rst);
endmodule

bind rst_seq_ctrl rsq_checker u_rsq_checker (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wd_en(wd_en),
    .sys_rst(sys_rst), .rst_cause(rst_cause), .ccr_set(ccr_set)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
    localparam int WDB = 4;
    localparam int HLD = 16;

    logic clk = 1'b0, ref_clk = 1'b0, clk_run = 1'b1;
    logic por_n = 1'b0, ext_rst_n = 1'b1, wd_en = 1'b0, svc_we = 1'b0, cm_en = 1'b0;
    logic [1:0] wd_scale = 2'd0;
    logic [7:0] svc_data = 8'h00;
    logic sys_rst, ccr_set;
    logic [1:0] rst_cause;

    int n_chk = 0, n_bad = 0;
    logic [1:0] exp_q[$];
    logic prev_rst = 1'b1;

    rst_seq_ctrl #(.WD_DIV_BITS(WDB), .HOLD_CYCLES(HLD)) u0 (
        .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .wd_en(wd_en), .wd_scale(wd_scale), .svc_we(svc_we), .svc_data(svc_data),
        .cm_en(cm_en), .sys_rst(sys_rst), .rst_cause(rst_cause), .ccr_set(ccr_set)
    );

    initial forever begin
        #2.5;
        if (clk_run) clk = !clk;
        else         clk = 1'b0;
    end
    initial forever #3.5 ref_clk = !ref_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_cause(input logic [1:0] c);
        exp_q.push_back(c);
    endtask

    // Monitor: pops expected cause on each reset entry, checks the release pulse.
    always @(negedge clk) begin
        if (sys_rst && !prev_rst) begin
            if (exp_q.size() == 0)
                check(1'b0, "R9 unexpected reset entry, cause", int'(rst_cause), -1);
            else begin
                automatic logic [1:0] e = exp_q.pop_front();
                check(rst_cause == e, "R9 recorded cause (R2/R4/R7)", int'(rst_cause), int'(e));
            end
        end
        if (!sys_rst && prev_rst)
            check(ccr_set == 1'b1, "R8 ccr_set on release", int'(ccr_set), 1);
        prev_rst = sys_rst;
    end

    task automatic wd_timeout(input logic [1:0] sc, input int n);
        expect_cause(2'b10);
        wd_scale = sc; wd_en = 1'b1;
        repeat (n - 1) @(negedge clk);
        check(sys_rst == 1'b0, "R4 no reset before terminal count", int'(sys_rst), 0);
        @(negedge clk);
        check(sys_rst == 1'b1, "R4 reset at terminal count", int'(sys_rst), 1);
        wd_en = 1'b0;
        repeat (HLD) @(negedge clk);
        check(sys_rst == 1'b0, "R3 released after hold", int'(sys_rst), 0);
    endtask

    task automatic svc_write(input logic [7:0] d);
        svc_we = 1'b1; svc_data = d;
        @(negedge clk);
        svc_we = 1'b0;
    endtask

    // Watchdog run where a service pattern lands on edges 10 and 11; restart decides the firing edge.
    task automatic wd_service(input logic [7:0] a, input logic [7:0] b, input int fire_at, input string req);
        expect_cause(2'b10);
        wd_scale = 2'd0; wd_en = 1'b1;
        repeat (9) @(negedge clk);
        svc_write(a);
        svc_write(b);
        repeat (fire_at - 12) @(negedge clk);
        check(sys_rst == 1'b0, req, int'(sys_rst), 0);
        @(negedge clk);
        check(sys_rst == 1'b1, req, int'(sys_rst), 1);
        wd_en = 1'b0;
        repeat (HLD) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sys_rst == 1'b1, "R1 reset while por_n low", int'(sys_rst), 1);
        por_n = 1'b1;
        repeat (4063) @(negedge clk);
        check(sys_rst == 1'b1, "R1 held until edge 4064", int'(sys_rst), 1);
        @(negedge clk);
        check(sys_rst == 1'b0, "R1 released at edge 4064", int'(sys_rst), 0);
        check(rst_cause == 2'b00, "R1 power-up cause", int'(rst_cause), 0);

        // R2 short pulse: five low edges only
        ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sys_rst == 1'b0, "R2 five-cycle pulse ignored", int'(sys_rst), 0);

        // R2 / R3 six-cycle pulse held longer
        expect_cause(2'b01);
        ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(sys_rst == 1'b0, "R2 not yet at fifth low edge", int'(sys_rst), 0);
        @(negedge clk);
        check(sys_rst == 1'b1, "R2 reset at sixth low edge", int'(sys_rst), 1);
        repeat (10) @(negedge clk);
        check(sys_rst == 1'b1, "R3 held while pin low", int'(sys_rst), 1);
        ext_rst_n = 1'b1;
        repeat (HLD - 1) @(negedge clk);
        check(sys_rst == 1'b1, "R3 held one edge before end", int'(sys_rst), 1);
        @(negedge clk);
        check(sys_rst == 1'b0, "R3 released after hold", int'(sys_rst), 0);
        repeat (50) @(negedge clk);
        check(rst_cause == 2'b01, "R10 cause kept in run", int'(rst_cause), 1);

        // R4 scale factors
        wd_timeout(2'd0, 16);
        wd_timeout(2'd1, 32);
        wd_timeout(2'd2, 64);
        wd_timeout(2'd3, 64);

        // R5 service key handling
        wd_service(8'h55, 8'hAA, 27, "R5 valid key restarts count");
        wd_service(8'h00, 8'hAA, 16, "R5 kick without arm ignored");
        wd_service(8'h55, 8'h12, 16, "R5 other value cancels key");

        // R6 disabled watchdog
        repeat (100) @(negedge clk);
        check(sys_rst == 1'b0, "R6 no reset with wd_en low", int'(sys_rst), 0);
        check(rst_cause == 2'b10, "R10 cause kept after idle run", int'(rst_cause), 2);

        // R9 pin filter and watchdog finish on the same edge
        expect_cause(2'b01);
        wd_scale = 2'd0; wd_en = 1'b1;
        repeat (10) @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(sys_rst == 1'b0, "R9 no reset before collision", int'(sys_rst), 0);
        @(negedge clk);
        check(sys_rst == 1'b1 && rst_cause == 2'b01, "R9 pin beats watchdog", int'(rst_cause), 1);
        wd_en = 1'b0; ext_rst_n = 1'b1;
        repeat (HLD) @(negedge clk);
        check(sys_rst == 1'b0, "R9 released after collision", int'(sys_rst), 0);

        // R7 monitor disabled: stopped clock is harmless
        clk_run = 1'b0;
        #140;
        check(sys_rst == 1'b0, "R7 disabled monitor no reset", int'(sys_rst), 0);
        clk_run = 1'b1;
        repeat (10) @(negedge clk);
        check(sys_rst == 1'b0 && rst_cause == 2'b01, "R7 disabled monitor cause", int'(rst_cause), 1);

        // R7 monitor enabled
        cm_en = 1'b1;
        repeat (6) @(negedge clk);
        expect_cause(2'b11);
        clk_run = 1'b0;
        #140;
        check(sys_rst == 1'b1, "R7 reset with clock stopped", int'(sys_rst), 1);
        clk_run = 1'b1;
        repeat (40) @(negedge clk);
        check(sys_rst == 1'b0, "R7 released after clock returns", int'(sys_rst), 0);
        check(rst_cause == 2'b11, "R7 clock-loss cause", int'(rst_cause), 3);
        cm_en = 1'b0;
        repeat (5) @(negedge clk);

        check(exp_q.size() == 0, "R9 all expected resets seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule